// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of several DMA channels gets the single shared bus master port next. Each channel drives a request line, a 2-bit software level and a flag that marks it as a memory-to-memory channel. The arbiter registers a one-hot grant together with the binary index of the winner. It then holds that grant until the bus side returns a one-cycle transfer-done pulse. After that pulse the port is free and a fresh choice is made from the requests pending at that time.

The choice is made in two stages. The highest software level wins first. Among channels that share that level, the lowest channel index wins. A memory-to-memory channel gives up the port after each item, and the next choice leaves it out whenever any other channel is waiting. A channel of lower priority can therefore get a turn between its items.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it, `grant` is all zero and `grant_valid` is 0.
- R2: Among requesting channels, the one whose level field has the largest value wins. The level encoding is 3 = very high, 2 = high, 1 = medium, 0 = low. Channel i's level sits in `prio[2*i+1:2*i]`.
- R3: When several requesting channels share the top level, the lowest index wins.
- R4: With the port idle and at least one request present at a clock edge, the grant appears after that edge. `grant` is one-hot, `grant[grant_idx]` is 1, and the granted channel was requesting at that edge.
- R5: Until `xfer_done` is seen, `grant` and `grant_idx` stay stable, even if the granted request drops or a higher-priority request arrives.
- R6: The edge that samples `xfer_done` high while a grant is held clears the grant. The next selection is made at the following edge.
- R7: With no request pending and the port idle, no grant is asserted.
- R8: After an item done by a channel whose `m2m` bit was set, the next selection excludes that channel if any other channel is requesting, even one of lower priority. If it is the only requester, it is granted again.
- R9: `xfer_done` while no grant is held has no effect.
- R10: After an item done by a channel whose `m2m` bit is clear, that channel takes part normally in the next selection and wins again if it still ranks highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NCH | Request line per channel |
| prio | input | 2*NCH | Software level per channel, 2 bits each |
| m2m | input | NCH | Channel is in memory-to-memory mode |
| xfer_done | input | 1 | One-cycle pulse: the granted transfer finished |
| grant | output | NCH | One-hot grant |
| grant_idx | output | max(1,clog2(NCH)) | Index of the granted channel |
| grant_valid | output | 1 | A grant is held |

## Verification
The bench builds the arbiter with NCH = 4. At that size every request pattern can be combined with every assignment of levels: 16 × 256 cases. The bench computes the expected winner for each case by a plain scan and compares it with the registered grant, so every level ordering and every tie-break position is covered. Directed sequences at the same size cover holding the grant, the done pulse while idle, and the memory-to-memory hand-over in both its outcomes.

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int NCH = 8,
  parameter int PW  = 2,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    req,
  input  logic [NCH*PW-1:0] prio,
  input  logic [NCH-1:0]    m2m,
  input  logic              xfer_done,
  output logic [NCH-1:0]    grant,
  output logic [IW-1:0]     grant_idx,
  output logic              grant_valid
);

  logic [NCH-1:0] skip_q;
  logic [NCH-1:0] others;
  logic [NCH-1:0] cand;
  logic [IW-1:0]  sel_idx;
  logic [PW-1:0]  best_lvl;
  logic           found;

  assign grant_valid = |grant;
  assign others      = req & ~skip_q;
  assign cand        = (|others) ? others : req;

  always_comb begin
    sel_idx  = '0;
    best_lvl = '0;
    found    = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio[i*PW +: PW] >= best_lvl)) begin
        found    = 1'b1;
        best_lvl = prio[i*PW +: PW];
        sel_idx  = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= '0;
      grant_idx <= '0;
      skip_q    <= '0;
    end else if (grant_valid) begin
      if (xfer_done) begin
        grant  <= '0;
        skip_q <= grant & m2m;
      end
    end else if (found) begin
      grant     <= NCH'(1) << sel_idx;
      grant_idx <= sel_idx;
      skip_q    <= '0;
    end
  end

endmodule

module dma_prio_arbiter_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic           xfer_done,
  input logic [NCH-1:0] grant,
  input logic           grant_valid
);

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  assert_idle_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && req != '0) |=> grant_valid);

  assert_pick_requested_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |=> (!grant_valid || ((grant & $past(req)) != '0)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !xfer_done) |=> $stable(grant));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && xfer_done) |=> !grant_valid);

  assert_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_valid && req == '0) |=> !grant_valid);

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
  .grant(grant), .grant_valid(grant_valid)
);

// File: tb/dma_prio_arbiter_bench.sv
module dma_prio_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int IW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req = '0;
  logic [2*N-1:0] prio = '0;
  logic [N-1:0]   m2m = '0;
  logic           xfer_done = 1'b0;
  logic [N-1:0]   grant;
  logic [IW-1:0]  grant_idx;
  logic           grant_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prio_arbiter #(.NCH(N)) u_dma_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .m2m(m2m),
    .xfer_done(xfer_done), .grant(grant), .grant_idx(grant_idx),
    .grant_valid(grant_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int model(input logic [N-1:0] r, input logic [2*N-1:0] p);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (r[i] && (best < 0 || p[2*i +: 2] > p[2*best +: 2])) best = i;
    return best;
  endfunction

  task automatic expect_grant(input int ch, input string tag);
    if (ch < 0) chk(!grant_valid && grant == '0, tag, int'(grant), 0);
    else chk(grant_valid && grant == N'(1 << ch) && grant_idx == IW'(ch),
             tag, int'(grant_idx) + (grant_valid ? 0 : 100), ch);
  endtask

  task automatic finish_item();
    xfer_done = 1'b1;
    cyc();
    xfer_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    expect_grant(-1, "R1 in reset");
    req = 4'b1111;
    cyc();
    expect_grant(-1, "R1 held in reset");
    req = '0;
    rst_n = 1'b1;
    cyc();
    expect_grant(-1, "R1 after reset");

    // R2 R3 R4 R7 sweep of all request and level combinations
    for (int r = 0; r < 16; r++) begin
      for (int p = 0; p < 256; p++) begin
        req = N'(r); prio = 8'(p);
        cyc();
        expect_grant(model(N'(r), 8'(p)), "R2_R3 sweep");
        req = '0;
        if (grant_valid) begin
          finish_item();
          expect_grant(-1, "R6 release");
        end
        cyc();
        expect_grant(-1, "R7 idle");
      end
    end

    // R9 done while idle
    xfer_done = 1'b1; cyc(); xfer_done = 1'b0; cyc();
    expect_grant(-1, "R9 done idle");
    req = 4'b0100; prio = 8'b00_01_00_00;
    cyc();
    expect_grant(2, "R9 normal after stray done");

    // R5 hold while request drops and higher arrives
    req = 4'b0001; prio = 8'b00_00_00_11;
    cyc(); cyc(); cyc();
    expect_grant(2, "R5 hold");
    // R6 release then new selection a cycle later
    finish_item();
    expect_grant(-1, "R6 gap cycle");
    cyc();
    expect_grant(0, "R6 next pick");
    req = '0; finish_item(); cyc();

    // R8 m2m hand-over to lower priority
    m2m = 4'b0001; prio = 8'b00_00_00_11; req = 4'b1001;
    cyc();
    expect_grant(0, "R8 m2m first");
    finish_item(); cyc();
    expect_grant(3, "R8 lower served between items");
    finish_item(); cyc();
    expect_grant(0, "R8 m2m resumes");
    req = 4'b0001;
    finish_item(); cyc();
    expect_grant(0, "R8 m2m sole requester regranted");
    req = '0; finish_item(); cyc();

    // R10 non-m2m highest channel regranted
    m2m = '0; prio = 8'b00_00_11_00; req = 4'b0110;
    cyc();
    expect_grant(1, "R10 first");
    finish_item(); cyc();
    expect_grant(1, "R10 regranted");
    req = '0; finish_item(); cyc();
    expect_grant(-1, "R7 final idle");

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule